// File: doc/BRIEF.md
# Six-Stage Pipeline Stall Controller

This block owns the occupancy and advance control of an in-order, single-issue processor pipeline with six stages: fetch, decode, execute, memory, align and writeback. Each stage holds a valid flag and an instruction tag. Every cycle the block decides which stages load, which stage is loaded with an empty slot, and whether a new instruction token can enter fetch. The instruction leaving writeback is reported with a retire strobe and its tag.

Stall requests come from exactly two places. The decode stage raises a one-bit interlock when its instruction needs a result that a long-latency operation has not produced yet. The align stage presents a vector of busy causes, such as a memory access still waiting on the data bus, a multicycle shift or divide still running, or a custom operation holding its stall line. A request freezes its own stage and every stage before it. The stages after it keep moving, and the stage just after the stall point takes in an empty slot. Empty slots are never closed up by letting frozen stages catch up.

Top module: `pipe_stall_ctrl`

## Requirements
- R1: Stage index 0..5 in `stage_vld`, `stage_en` and `bubble_ins` means fetch, decode, execute, memory, align, writeback. With no stall, every stage loads from the one before it each cycle. Fetch loads `in_valid`/`in_tag`, so an accepted token reaches stage i after i+1 rising edges. `stage_tag` holds stage i's tag in bits [i*TAG_W +: TAG_W].
- R2: At most one token enters fetch per cycle (`in_valid` and `in_ready` both high) and at most one retires. The sequence of retired tags equals the sequence of accepted tags, with no loss and no duplication.
- R3: An align stall is any bit of `align_busy` set while the align stage holds a valid instruction. During it, stages 0..4 keep their valid bits and tags, `stage_en[4:0]` is 0 and `in_ready` is 0.
- R4: During an align stall, writeback loads an empty slot: `bubble_ins` is 6'b100000, and one edge later `stage_vld[5]` is 0.
- R5: A decode stall is `dec_hold` high while decode holds a valid instruction and there is no align stall. During it, fetch and decode hold, execute loads an empty slot (`bubble_ins` = 6'b000100), and memory, align and writeback advance.
- R6: A frozen stage stays frozen even when the stage after it is empty. Empty slots ahead of a freeze are never filled by catching up.
- R7: When an align stall and a decode stall are requested together, the align stage is the freeze boundary.
- R8: A stall request from a stage that holds no valid instruction has no effect. `in_ready` stays 1 and every stage loads.
- R9: A synchronous active-high `rst` clears all valid bits at the next rising edge, and `retire` is 0 after it.
- R10: `retire` is high exactly when writeback holds a valid instruction, and `retire_tag` equals that instruction's tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction token offered to fetch |
| in_tag | input | TAG_W | Tag of the offered token |
| in_ready | output | 1 | Fetch loads this cycle (token accepted when in_valid is also high) |
| dec_hold | input | 1 | Decode interlock request |
| align_busy | input | N_CAUSE | Align-stage busy causes, one bit each |
| stage_en | output | 6 | Per-stage load enable |
| bubble_ins | output | 6 | Stage being loaded with an empty slot this cycle |
| stage_vld | output | 6 | Per-stage valid flags |
| stage_tag | output | 6*TAG_W | Per-stage tags, stage i at [i*TAG_W +: TAG_W] |
| retire | output | 1 | A valid instruction leaves writeback this cycle |
| retire_tag | output | TAG_W | Tag of the retiring instruction |

## Verification
The hardest case to reach from the ports is a freeze while empty slots already sit between the frozen stages and the stages still draining. Worse still is a decode request and an align request landing together while a gap is moving through execute and memory. A naive random stream rarely lines these up. Directed sequences first open gaps by lowering `in_valid`, then hold both requests. A long random phase then mixes sparse input, frequent decode holds and multi-bit busy vectors. A scoreboard on the accepted and retired tags and a cycle model of the slots catch any catch-up, loss or duplication.

// File: rtl/pipe_stall_pkg.sv
package pipe_stall_pkg;

  localparam int NUM_STAGES = 6;
  localparam int IDX_W      = $clog2(NUM_STAGES);

  localparam int ST_F = 0;
  localparam int ST_D = 1;
  localparam int ST_E = 2;
  localparam int ST_M = 3;
  localparam int ST_A = 4;
  localparam int ST_W = 5;

  typedef logic [NUM_STAGES-1:0] stage_mask_t;

  typedef struct packed {
    logic             active;
    logic [IDX_W-1:0] point;
  } freeze_t;

  // Stages strictly after the freeze point load; all load when no freeze.
  function automatic stage_mask_t load_mask(freeze_t f);
    stage_mask_t m;
    for (int i = 0; i < NUM_STAGES; i++) begin
      m[i] = !f.active || (i > int'(f.point));
    end
    return m;
  endfunction

  // The single stage right after the freeze point takes an empty slot.
  function automatic stage_mask_t bubble_mask(freeze_t f);
    stage_mask_t m;
    for (int i = 0; i < NUM_STAGES; i++) begin
      m[i] = f.active && (i == int'(f.point) + 1);
    end
    return m;
  endfunction

endpackage

// File: rtl/pipe_stall_arb.sv
module pipe_stall_arb
  import pipe_stall_pkg::*;
#(
  parameter int N_CAUSE = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               dec_vld,
  input  logic               aln_vld,
  input  logic               dec_hold,
  input  logic [N_CAUSE-1:0] align_busy,
  output logic               aln_stall_evt,
  output logic               dec_stall_evt,
  output freeze_t            frz
);

  logic any_cause;

  assign any_cause     = |align_busy;
  assign aln_stall_evt = aln_vld && any_cause;
  assign dec_stall_evt = dec_vld && dec_hold;

  always_comb begin
    frz = '0;
    if (aln_stall_evt) begin
      frz.active = 1'b1;
      frz.point  = IDX_W'(ST_A);
    end else if (dec_stall_evt) begin
      frz.active = 1'b1;
      frz.point  = IDX_W'(ST_D);
    end
  end

  AST_ALIGN_WINS: assert property (@(posedge clk) disable iff (rst)
    (dec_vld && dec_hold && aln_vld && (|align_busy)) |-> (frz.point == IDX_W'(ST_A))); // R7

  AST_IDLE_REQ_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (!dec_vld && !aln_vld) |-> !frz.active); // R8

endmodule

// File: rtl/pipe_slot.sv
module pipe_slot #(
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             bubble,
  input  logic             d_vld,
  input  logic [TAG_W-1:0] d_tag,
  output logic             q_vld,
  output logic [TAG_W-1:0] q_tag
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q_vld <= 1'b0;
      q_tag <= '0;
    end else if (load) begin
      q_vld <= d_vld && !bubble;
      q_tag <= d_tag;
    end
  end

  AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(q_vld) && $stable(q_tag))); // R3

  AST_SLOT_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (load && bubble) |=> !q_vld); // R4

endmodule

// File: rtl/pipe_stall_ctrl.sv
module pipe_stall_ctrl
  import pipe_stall_pkg::*;
#(
  parameter int TAG_W   = 8,
  parameter int N_CAUSE = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_valid,
  input  logic [TAG_W-1:0]            in_tag,
  output logic                        in_ready,
  input  logic                        dec_hold,
  input  logic [N_CAUSE-1:0]          align_busy,
  output logic [NUM_STAGES-1:0]       stage_en,
  output logic [NUM_STAGES-1:0]       bubble_ins,
  output logic [NUM_STAGES-1:0]       stage_vld,
  output logic [NUM_STAGES*TAG_W-1:0] stage_tag,
  output logic                        retire,
  output logic [TAG_W-1:0]            retire_tag
);

  freeze_t           frz;
  logic              aln_stall_evt;
  logic              dec_stall_evt;
  logic              accept_evt;
  stage_mask_t       ld_mask;
  stage_mask_t       bub_mask;
  logic [TAG_W-1:0]  tag_q [NUM_STAGES];

  pipe_stall_arb #(.N_CAUSE(N_CAUSE)) u_arb (
    .clk          (clk),
    .rst          (rst),
    .dec_vld      (stage_vld[ST_D]),
    .aln_vld      (stage_vld[ST_A]),
    .dec_hold     (dec_hold),
    .align_busy   (align_busy),
    .aln_stall_evt(aln_stall_evt),
    .dec_stall_evt(dec_stall_evt),
    .frz          (frz)
  );

  assign ld_mask  = load_mask(frz);
  assign bub_mask = bubble_mask(frz);

  for (genvar i = 0; i < NUM_STAGES; i++) begin : g_slot
    logic             src_vld;
    logic [TAG_W-1:0] src_tag;
    if (i == 0) begin : g_head
      assign src_vld = in_valid;
      assign src_tag = in_tag;
    end else begin : g_link
      assign src_vld = stage_vld[i-1];
      assign src_tag = tag_q[i-1];
    end
    pipe_slot #(.TAG_W(TAG_W)) u_slot (
      .clk   (clk),
      .rst   (rst),
      .load  (ld_mask[i]),
      .bubble(bub_mask[i]),
      .d_vld (src_vld),
      .d_tag (src_tag),
      .q_vld (stage_vld[i]),
      .q_tag (tag_q[i])
    );
    assign stage_tag[i*TAG_W +: TAG_W] = tag_q[i];
  end

  assign stage_en   = ld_mask;
  assign bubble_ins = bub_mask;
  assign in_ready   = ld_mask[ST_F];
  assign accept_evt = in_valid && in_ready;
  assign retire     = stage_vld[ST_W];
  assign retire_tag = tag_q[ST_W];

  AST_RESET_EMPTY: assert property (@(posedge clk)
    rst |=> (stage_vld == '0)); // R9

  AST_ALIGN_FREEZE: assert property (@(posedge clk) disable iff (rst)
    aln_stall_evt |=> ($stable(stage_vld[ST_A:ST_F]) && $stable(stage_tag[ST_W*TAG_W-1:0]))); // R3

  AST_WB_BUBBLE: assert property (@(posedge clk) disable iff (rst)
    aln_stall_evt |=> !retire); // R4

  AST_DEC_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (dec_stall_evt && !aln_stall_evt) |=> (!stage_vld[ST_E] && $stable(stage_vld[ST_D:ST_F]))); // R5

  AST_TAIL_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    !aln_stall_evt |=> (stage_vld[ST_W] == $past(stage_vld[ST_A]))); // R1

  AST_NO_CATCHUP: assert property (@(posedge clk) disable iff (rst)
    (dec_stall_evt && !stage_vld[ST_E]) |-> !stage_en[ST_D]); // R6

  AST_ONE_BUBBLE: assert property (@(posedge clk) disable iff (rst)
    $countones(bubble_ins) <= 1); // R2

  AST_ACCEPT_ONLY_READY: assert property (@(posedge clk) disable iff (rst)
    accept_evt |=> (stage_vld[ST_F] && stage_tag[TAG_W-1:0] == $past(in_tag))); // R2

endmodule

// File: tb/pipe_stall_ctrl_bench.sv
module pipe_stall_ctrl_bench;
  localparam int TAG_W = 8;
  localparam int NC    = 4;
  localparam int NS    = 6;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_valid = 1'b0;
  logic [TAG_W-1:0]  in_tag = '0;
  logic              in_ready;
  logic              dec_hold = 1'b0;
  logic [NC-1:0]     align_busy = '0;
  logic [NS-1:0]     stage_en, bubble_ins, stage_vld;
  logic [NS*TAG_W-1:0] stage_tag;
  logic              retire;
  logic [TAG_W-1:0]  retire_tag;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;
  bit          mv [NS];
  logic [TAG_W-1:0] mt [NS];
  logic [TAG_W-1:0] sb [$];
  logic [TAG_W-1:0] next_tag = 8'd1;

  pipe_stall_ctrl #(.TAG_W(TAG_W), .N_CAUSE(NC)) u_pipe_stall_ctrl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_tag(in_tag), .in_ready(in_ready),
    .dec_hold(dec_hold), .align_busy(align_busy), .stage_en(stage_en),
    .bubble_ins(bubble_ins), .stage_vld(stage_vld), .stage_tag(stage_tag),
    .retire(retire), .retire_tag(retire_tag)
  );

  always #2 clk = ~clk;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Freeze boundary from the requirements: align (4) beats decode (1); -1 none.
  function automatic int freeze_at(logic dh, logic [NC-1:0] ab);
    if (mv[4] && ab != '0) return 4;
    if (mv[1] && dh) return 1;
    return -1;
  endfunction

  function automatic logic [NS-1:0] model_vld();
    logic [NS-1:0] v;
    for (int i = 0; i < NS; i++) v[i] = mv[i];
    return v;
  endfunction

  // One cycle: drive at negedge, check outputs, advance model across posedge.
  task automatic step(logic iv, logic dh, logic [NC-1:0] ab);
    int lim;
    logic [NS-1:0] exp_en, exp_bub;
    bit nv [NS];
    logic [TAG_W-1:0] nt [NS];
    in_valid = iv; in_tag = next_tag; dec_hold = dh; align_busy = ab;
    #1;
    lim = freeze_at(dh, ab);
    for (int i = 0; i < NS; i++) begin
      exp_en[i]  = (i > lim);
      exp_bub[i] = (lim >= 0) && (i == lim + 1);
    end
    chk("R1 stage_vld", 64'(stage_vld), 64'(model_vld()));
    for (int i = 0; i < NS; i++)
      if (mv[i]) chk("R1 stage_tag", 64'(stage_tag[i*TAG_W +: TAG_W]), 64'(mt[i]));
    chk(lim == 4 ? "R3 R7 stage_en" : (lim == 1 ? "R5 R6 stage_en" : "R8 stage_en"),
        64'(stage_en), 64'(exp_en));
    chk(lim == 4 ? "R4 bubble_ins" : "R5 bubble_ins", 64'(bubble_ins), 64'(exp_bub));
    chk("R3 in_ready", 64'(in_ready), 64'(lim < 0));
    chk("R10 retire", 64'(retire), 64'(mv[5]));
    if (mv[5]) begin
      chk("R10 retire_tag", 64'(retire_tag), 64'(mt[5]));
      if (sb.size() == 0) chk("R2 retire without dispatch", 64'(1), 64'(0));
      else chk("R2 retire order", 64'(retire_tag), 64'(sb.pop_front()));
    end
    for (int i = 0; i < NS; i++) begin
      if (i > lim) begin
        if (i == 0) begin nv[i] = iv; nt[i] = next_tag; end
        else begin nv[i] = (i == lim + 1) ? 1'b0 : mv[i-1]; nt[i] = mt[i-1]; end
      end else begin
        nv[i] = mv[i]; nt[i] = mt[i];
      end
    end
    if (iv && lim < 0) begin sb.push_back(next_tag); next_tag = next_tag + 8'd1; end
    for (int i = 0; i < NS; i++) begin mv[i] = nv[i]; mt[i] = nt[i]; end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    for (int i = 0; i < NS; i++) begin mv[i] = 1'b0; mt[i] = '0; end
    sb.delete();
    chk("R9 valid cleared", 64'(stage_vld), 64'(0));
    chk("R9 retire low", 64'(retire), 64'(0));
    rst = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    do_reset();
    // R8: requests with empty decode/align slots are ignored.
    step(1'b1, 1'b1, 4'hF);
    step(1'b0, 1'b1, 4'hF);
    // R1: fill with no stalls, gaps included.
    for (int k = 0; k < 8; k++) step(k != 3, 1'b0, '0);
    // R3 R4: align stall for several cycles.
    for (int k = 0; k < 4; k++) step(1'b1, 1'b0, 4'b0100);
    // R5 R6: decode hold with gaps downstream.
    step(1'b0, 1'b0, '0);
    step(1'b0, 1'b0, '0);
    for (int k = 0; k < 4; k++) step(1'b1, 1'b1, '0);
    // R7: both requests together.
    for (int k = 0; k < 3; k++) step(1'b1, 1'b1, 4'b1001);
    for (int k = 0; k < 6; k++) step(1'b1, 1'b0, '0);
    // R9: reset while full.
    do_reset();
    // Random phase.
    for (int k = 0; k < 4000; k++) begin
      logic iv, dh;
      logic [NC-1:0] ab;
      iv = ($urandom % 10) < 7;
      dh = ($urandom % 10) < 3;
      ab = (($urandom % 10) < 2) ? NC'($urandom) : '0;
      step(iv, dh, ab);
    end
    // R2: drain, every accepted tag must have retired.
    for (int k = 0; k < 12; k++) step(1'b0, 1'b0, '0);
    chk("R2 all dispatched retired", 64'(sb.size()), 64'(0));
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule